// File: doc/BRIEF.md
# VLIW Packet Register-Port Conflict Checker

This block inspects one execute packet for a two-sided VLIW signal processor before the packet issues. The machine has two register files, A and B, of sixteen 32-bit registers each. Slots 0 to 3 form side A and write only file A. Slots 4 to 7 form side B and write only file B. Each slot presents a descriptor: a valid bit, two source indices with enables, and a destination index with an enable. It also carries a flag that makes the first source a 40-bit pair read, a flag that makes the destination a 40-bit pair write, and a flag that routes the second source across to the opposite file. A memory-access flag comes with an address-pointer index and the file that pointer lives in.

The block reports a registered violation vector, with one bit per rule, and a legal bit. A packet is accepted on a cycle where `in_valid` is high. Its verdict appears on the next cycle together with `out_valid`. Between packets the verdict holds its last value. Issue logic stalls or rejects the packet whenever `legal` is low.

Top module: `vliw_port_checker`

## Requirements
- R1: After reset `out_valid` is 0 and `viol` is 0. `out_valid` equals the `in_valid` of the previous cycle, and a verdict appears exactly one cycle after its packet.
- R2: `viol[0]` is set when, on one side, two or more valid slots read their second source across the cross path (second source enabled and cross flag set). One such read per side is legal.
- R3: `viol[1]` is set when any enabled 40-bit reference has an odd base index. This covers both a pair read on the first source and a pair write on the destination.
- R4: `viol[2]` is set when two or more valid slots on the same side write 40-bit pairs.
- R5: `viol[3]` is set when one side has both a 40-bit read and a 40-bit write in the same packet. A pair read on one side together with a pair write on the other side is legal.
- R6: `viol[4]` is set when two valid memory-access slots take their address pointers from the same file (pointer file bit 0 = A, 1 = B).
- R7: `viol[5]` is set when any single register is read more than four times in a packet. Both halves of a pair read count, and so do cross reads and pointer reads. Exactly four reads is legal.
- R8: `viol[6]` is set when two valid slots write the same register of the same file. A 40-bit write at base n covers registers n and n|1. The same index in different files is legal.
- R9: Slots whose valid bit is 0 have no effect on any violation bit.
- R10: `legal` is 1 exactly when all bits of `viol` are 0. Several violations in one packet set several bits at once.
- R11: While `in_valid` is low, `viol` and `legal` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet strobe |
| slot_vld | input | 8 | Per-slot valid |
| src0_idx | input | 32 | First source index, 4 bits per slot |
| src0_en | input | 8 | First source used |
| src1_idx | input | 32 | Second source index, 4 bits per slot |
| src1_en | input | 8 | Second source used |
| dst_idx | input | 32 | Destination index, 4 bits per slot |
| dst_en | input | 8 | Destination used |
| pair_rd | input | 8 | First source is a 40-bit pair |
| pair_wr | input | 8 | Destination is a 40-bit pair |
| xpath | input | 8 | Second source comes from the opposite file |
| mem_acc | input | 8 | Slot is a memory access |
| ptr_idx | input | 32 | Address-pointer index, 4 bits per slot |
| ptr_file | input | 8 | Pointer file (0 = A, 1 = B) |
| out_valid | output | 1 | Verdict valid |
| legal | output | 1 | Packet may issue |
| viol | output | 7 | Violation bits as listed in R2 to R8 |

## Verification
The bench builds the block with its default parameters: four slots per side, 4-bit register indices and a read limit of four. With eight slots each able to produce up to three reads, a single register can reach well past the limit, so both the exact-four and the five-read cases are reachable. Sixteen registers per file leave room for odd and even pair bases, and for overlapping pair and single writes. Each rule is driven on one side and then as a legal near-miss on the other side or in the other file.

// File: rtl/vchk_pkg.sv
package vchk_pkg;
  localparam int VIOL_W      = 7;
  localparam int V_XPATH     = 0;
  localparam int V_PAIR_ODD  = 1;
  localparam int V_PAIR_WR2  = 2;
  localparam int V_PAIR_RW   = 3;
  localparam int V_PTR_FILE  = 4;
  localparam int V_FANOUT    = 5;
  localparam int V_DUP_DST   = 6;

  typedef struct packed {
    logic xrd;    // cross-path read issued
    logic prd;    // 40-bit read issued
    logic pwr;    // 40-bit write issued
    logic odd;    // pair reference with odd base
    logic mem;    // memory access issued
    logic pfile;  // pointer file
  } slot_flags_t;
endpackage

// File: rtl/vchk_slot_decode.sv
module vchk_slot_decode
  import vchk_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter bit SIDE  = 1'b0,
  localparam int NBIT = 2 * (1 << IDX_W)
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] s0,
  input  logic             s0_en,
  input  logic [IDX_W-1:0] s1,
  input  logic             s1_en,
  input  logic [IDX_W-1:0] d,
  input  logic             d_en,
  input  logic             prd,
  input  logic             pwr,
  input  logic             xp,
  input  logic             mem,
  input  logic [IDX_W-1:0] p,
  input  logic             pf,
  output logic [NBIT-1:0]  rd0_m,
  output logic [NBIT-1:0]  rd1_m,
  output logic [NBIT-1:0]  rdp_m,
  output logic [NBIT-1:0]  wr_m,
  output slot_flags_t      flg
);
  always_comb begin
    rd0_m = '0;
    rd1_m = '0;
    rdp_m = '0;
    wr_m  = '0;
    if (vld && s0_en) begin
      rd0_m[{SIDE, s0}] = 1'b1;
      if (prd) rd0_m[{SIDE, s0[IDX_W-1:1], 1'b1}] = 1'b1;
    end
    if (vld && s1_en) rd1_m[{SIDE ^ xp, s1}] = 1'b1;
    if (vld && mem)   rdp_m[{pf, p}] = 1'b1;
    if (vld && d_en) begin
      wr_m[{SIDE, d}] = 1'b1;
      if (pwr) wr_m[{SIDE, d[IDX_W-1:1], 1'b1}] = 1'b1;
    end
  end

  always_comb begin
    flg.xrd   = vld & s1_en & xp;
    flg.prd   = vld & s0_en & prd;
    flg.pwr   = vld & d_en & pwr;
    flg.odd   = (flg.prd & s0[0]) | (flg.pwr & d[0]);
    flg.mem   = vld & mem;
    flg.pfile = pf;
  end
endmodule

// File: rtl/vchk_side_rules.sv
module vchk_side_rules #(
  parameter int SPS = 4
) (
  input  logic [SPS-1:0] xrd,
  input  logic [SPS-1:0] prd,
  input  logic [SPS-1:0] pwr,
  output logic           x_viol,
  output logic           ww_viol,
  output logic           rw_viol
);
  always_comb begin
    x_viol  = $countones(xrd) > 1;
    ww_viol = $countones(pwr) > 1;
    rw_viol = (|prd) & (|pwr);
  end
endmodule

// File: rtl/vchk_port_count.sv
module vchk_port_count #(
  parameter int NSLOT     = 8,
  parameter int NBIT      = 32,
  parameter int MAX_READS = 4
) (
  input  logic [NBIT-1:0] rd0_m [NSLOT],
  input  logic [NBIT-1:0] rd1_m [NSLOT],
  input  logic [NBIT-1:0] rdp_m [NSLOT],
  input  logic [NBIT-1:0] wr_m  [NSLOT],
  output logic            fan_viol,
  output logic            dup_viol
);
  int rc;
  int wc;

  always_comb begin
    fan_viol = 1'b0;
    dup_viol = 1'b0;
    rc = 0;
    wc = 0;
    for (int b = 0; b < NBIT; b++) begin
      rc = 0;
      wc = 0;
      for (int s = 0; s < NSLOT; s++) begin
        rc = rc + int'(rd0_m[s][b]) + int'(rd1_m[s][b]) + int'(rdp_m[s][b]);
        wc = wc + int'(wr_m[s][b]);
      end
      if (rc > MAX_READS) fan_viol = 1'b1;
      if (wc > 1)         dup_viol = 1'b1;
    end
  end
endmodule

// File: rtl/vliw_port_checker.sv
module vliw_port_checker
  import vchk_pkg::*;
#(
  parameter int SLOTS_PER_SIDE = 4,
  parameter int IDX_W          = 4,
  parameter int MAX_READS      = 4,
  localparam int NSLOT = 2 * SLOTS_PER_SIDE,
  localparam int NBIT  = 2 * (1 << IDX_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [NSLOT-1:0]       slot_vld,
  input  logic [NSLOT*IDX_W-1:0] src0_idx,
  input  logic [NSLOT-1:0]       src0_en,
  input  logic [NSLOT*IDX_W-1:0] src1_idx,
  input  logic [NSLOT-1:0]       src1_en,
  input  logic [NSLOT*IDX_W-1:0] dst_idx,
  input  logic [NSLOT-1:0]       dst_en,
  input  logic [NSLOT-1:0]       pair_rd,
  input  logic [NSLOT-1:0]       pair_wr,
  input  logic [NSLOT-1:0]       xpath,
  input  logic [NSLOT-1:0]       mem_acc,
  input  logic [NSLOT*IDX_W-1:0] ptr_idx,
  input  logic [NSLOT-1:0]       ptr_file,
  output logic                   out_valid,
  output logic                   legal,
  output logic [VIOL_W-1:0]      viol
);
  logic [NBIT-1:0]  rd0_m [NSLOT];
  logic [NBIT-1:0]  rd1_m [NSLOT];
  logic [NBIT-1:0]  rdp_m [NSLOT];
  logic [NBIT-1:0]  wr_m  [NSLOT];
  slot_flags_t      flg   [NSLOT];
  logic [NSLOT-1:0] xrd_v, prd_v, pwr_v, odd_v, mem_v, pf_v;
  logic [1:0]       x_side, ww_side, rw_side;
  logic             fan_viol, dup_viol, ptr_viol;
  logic [VIOL_W-1:0] viol_nxt;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam bit SD = (g >= SLOTS_PER_SIDE);
    vchk_slot_decode #(.IDX_W(IDX_W), .SIDE(SD)) u_dec (
      .vld   (slot_vld[g]),
      .s0    (src0_idx[g*IDX_W +: IDX_W]),
      .s0_en (src0_en[g]),
      .s1    (src1_idx[g*IDX_W +: IDX_W]),
      .s1_en (src1_en[g]),
      .d     (dst_idx[g*IDX_W +: IDX_W]),
      .d_en  (dst_en[g]),
      .prd   (pair_rd[g]),
      .pwr   (pair_wr[g]),
      .xp    (xpath[g]),
      .mem   (mem_acc[g]),
      .p     (ptr_idx[g*IDX_W +: IDX_W]),
      .pf    (ptr_file[g]),
      .rd0_m (rd0_m[g]),
      .rd1_m (rd1_m[g]),
      .rdp_m (rdp_m[g]),
      .wr_m  (wr_m[g]),
      .flg   (flg[g])
    );
    assign xrd_v[g] = flg[g].xrd;
    assign prd_v[g] = flg[g].prd;
    assign pwr_v[g] = flg[g].pwr;
    assign odd_v[g] = flg[g].odd;
    assign mem_v[g] = flg[g].mem;
    assign pf_v[g]  = flg[g].pfile;
  end

  for (genvar sd = 0; sd < 2; sd++) begin : g_side
    vchk_side_rules #(.SPS(SLOTS_PER_SIDE)) u_side (
      .xrd     (xrd_v[sd*SLOTS_PER_SIDE +: SLOTS_PER_SIDE]),
      .prd     (prd_v[sd*SLOTS_PER_SIDE +: SLOTS_PER_SIDE]),
      .pwr     (pwr_v[sd*SLOTS_PER_SIDE +: SLOTS_PER_SIDE]),
      .x_viol  (x_side[sd]),
      .ww_viol (ww_side[sd]),
      .rw_viol (rw_side[sd])
    );
  end

  vchk_port_count #(.NSLOT(NSLOT), .NBIT(NBIT), .MAX_READS(MAX_READS)) u_cnt (
    .rd0_m    (rd0_m),
    .rd1_m    (rd1_m),
    .rdp_m    (rdp_m),
    .wr_m     (wr_m),
    .fan_viol (fan_viol),
    .dup_viol (dup_viol)
  );

  always_comb begin
    ptr_viol = ($countones(mem_v & pf_v) > 1) || ($countones(mem_v & ~pf_v) > 1);
    viol_nxt             = '0;
    viol_nxt[V_XPATH]    = |x_side;
    viol_nxt[V_PAIR_ODD] = |odd_v;
    viol_nxt[V_PAIR_WR2] = |ww_side;
    viol_nxt[V_PAIR_RW]  = |rw_side;
    viol_nxt[V_PTR_FILE] = ptr_viol;
    viol_nxt[V_FANOUT]   = fan_viol;
    viol_nxt[V_DUP_DST]  = dup_viol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      viol      <= '0;
      legal     <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        viol  <= viol_nxt;
        legal <= ~|viol_nxt;
      end
    end
  end
endmodule

// File: rtl/vchk_packet_checker.sv
module vchk_packet_checker
  import vchk_pkg::*;
#(
  parameter int SLOTS_PER_SIDE = 4,
  localparam int NSLOT = 2 * SLOTS_PER_SIDE
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NSLOT-1:0]  slot_vld,
  input logic [NSLOT-1:0]  src1_en,
  input logic [NSLOT-1:0]  xpath,
  input logic [NSLOT-1:0]  mem_acc,
  input logic [NSLOT-1:0]  ptr_file,
  input logic              out_valid,
  input logic              legal,
  input logic [VIOL_W-1:0] viol
);
  assert_strobe_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_xpath_side_a_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(slot_vld[SLOTS_PER_SIDE-1:0] & src1_en[SLOTS_PER_SIDE-1:0]
                            & xpath[SLOTS_PER_SIDE-1:0]) > 1) |=> viol[V_XPATH]);
  assert_ptr_file_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (($countones(slot_vld & mem_acc & ptr_file) > 1) ||
                  ($countones(slot_vld & mem_acc & ~ptr_file) > 1))) |=> viol[V_PTR_FILE]);
  assert_idle_slots_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot_vld == '0) |=> (viol == '0 && legal));
  assert_legal_nor_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (legal == (viol == '0)));
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(viol) && $stable(legal)));
endmodule

bind vliw_port_checker vchk_packet_checker #(.SLOTS_PER_SIDE(SLOTS_PER_SIDE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .slot_vld  (slot_vld),
  .src1_en   (src1_en),
  .xpath     (xpath),
  .mem_acc   (mem_acc),
  .ptr_file  (ptr_file),
  .out_valid (out_valid),
  .legal     (legal),
  .viol      (viol)
);

// File: tb/tb_vliw_port_checker.sv
module tb_vliw_port_checker;
  localparam int NS = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NS-1:0]    slot_vld, src0_en, src1_en, dst_en, pair_rd, pair_wr, xpath, mem_acc, ptr_file;
  logic [NS*IW-1:0] src0_idx, src1_idx, dst_idx, ptr_idx;
  logic out_valid, legal;
  logic [6:0] viol;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [6:0] exp_q [$];
  string      tag_q [$];

  always #4ns clk = ~clk;

  vliw_port_checker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .slot_vld(slot_vld),
    .src0_idx(src0_idx), .src0_en(src0_en), .src1_idx(src1_idx), .src1_en(src1_en),
    .dst_idx(dst_idx), .dst_en(dst_en), .pair_rd(pair_rd), .pair_wr(pair_wr),
    .xpath(xpath), .mem_acc(mem_acc), .ptr_idx(ptr_idx), .ptr_file(ptr_file),
    .out_valid(out_valid), .legal(legal), .viol(viol)
  );

  task automatic check(string tag, logic [6:0] act_v, logic act_l, logic [6:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v || act_l !== (exp_v == 7'd0)) begin
      n_bad++;
      $display("FAIL %s viol=%b legal=%b expected viol=%b legal=%b",
               tag, act_v, act_l, exp_v, exp_v == 7'd0);
    end
  endtask

  // monitor: pops one expected verdict per output strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 out_valid=1 expected 0 (no packet pending)");
      end else begin
        check(tag_q.pop_front(), viol, legal, exp_q.pop_front());
      end
    end
  end

  task automatic clear_pkt();
    slot_vld = '0; src0_en = '0; src1_en = '0; dst_en = '0; pair_rd = '0; pair_wr = '0;
    xpath = '0; mem_acc = '0; ptr_file = '0;
    src0_idx = '0; src1_idx = '0; dst_idx = '0; ptr_idx = '0;
  endtask

  task automatic set_slot(int s, logic [3:0] a, logic ae, logic [3:0] b, logic be,
                          logic bx, logic [3:0] d, logic de);
    slot_vld[s] = 1'b1;
    src0_idx[s*IW +: IW] = a; src0_en[s] = ae;
    src1_idx[s*IW +: IW] = b; src1_en[s] = be; xpath[s] = bx;
    dst_idx[s*IW +: IW]  = d; dst_en[s]  = de;
  endtask

  task automatic set_pair(int s, logic r, logic w);
    pair_rd[s] = r; pair_wr[s] = w;
  endtask

  task automatic set_mem(int s, logic [3:0] p, logic f);
    mem_acc[s] = 1'b1; ptr_idx[s*IW +: IW] = p; ptr_file[s] = f;
  endtask

  // driver: issues the prepared packet and queues its expected verdict
  task automatic send(logic [6:0] exp_v, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    exp_q.push_back(exp_v);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    clear_pkt();
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_pkt();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || viol !== 7'd0) begin
      n_bad++;
      $display("FAIL R1 reset out_valid=%b viol=%b expected 0 / 0", out_valid, viol);
    end

    // clean packet, one cross read on side B
    set_slot(0, 4'd1, 1, 4'd2, 1, 0, 4'd3, 1);
    set_slot(4, 4'd1, 1, 4'd2, 1, 1, 4'd3, 1);
    send(7'b0000000, "R1 clean packet");

    // R2 two cross reads on side A
    set_slot(0, 4'd0, 0, 4'd5, 1, 1, 4'd0, 1);
    set_slot(1, 4'd0, 0, 4'd6, 1, 1, 4'd1, 1);
    send(7'b0000001, "R2 two cross reads side A");
    // R2 boundary: one per side
    set_slot(0, 4'd0, 0, 4'd5, 1, 1, 4'd0, 1);
    set_slot(5, 4'd0, 0, 4'd6, 1, 1, 4'd1, 1);
    send(7'b0000000, "R2 one cross read per side");

    // R3 odd pair write base, odd pair read base
    set_slot(2, 4'd0, 0, 4'd0, 0, 0, 4'd5, 1); set_pair(2, 0, 1);
    send(7'b0000010, "R3 odd pair write");
    set_slot(5, 4'd3, 1, 4'd0, 0, 0, 4'd0, 0); set_pair(5, 1, 0);
    send(7'b0000010, "R3 odd pair read");

    // R4 two pair writes side A; boundary one per side
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd2, 1); set_pair(0, 0, 1);
    set_slot(1, 4'd0, 0, 4'd0, 0, 0, 4'd4, 1); set_pair(1, 0, 1);
    send(7'b0000100, "R4 two pair writes side A");
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd2, 1); set_pair(0, 0, 1);
    set_slot(6, 4'd0, 0, 4'd0, 0, 0, 4'd2, 1); set_pair(6, 0, 1);
    send(7'b0000000, "R4 one pair write per side");

    // R5 pair read and write same side; boundary across sides
    set_slot(0, 4'd6, 1, 4'd0, 0, 0, 4'd0, 0); set_pair(0, 1, 0);
    set_slot(1, 4'd0, 0, 4'd0, 0, 0, 4'd8, 1); set_pair(1, 0, 1);
    send(7'b0001000, "R5 pair read+write side A");
    set_slot(4, 4'd6, 1, 4'd0, 0, 0, 4'd0, 0); set_pair(4, 1, 0);
    set_slot(1, 4'd0, 0, 4'd0, 0, 0, 4'd8, 1); set_pair(1, 0, 1);
    send(7'b0000000, "R5 pair read B, pair write A");

    // R6 pointers from same file; boundary different files
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd0, 0); set_mem(0, 4'd1, 0);
    set_slot(4, 4'd0, 0, 4'd0, 0, 0, 4'd0, 0); set_mem(4, 4'd2, 0);
    send(7'b0010000, "R6 two pointers file A");
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd0, 0); set_mem(0, 4'd1, 0);
    set_slot(4, 4'd0, 0, 4'd0, 0, 0, 4'd0, 0); set_mem(4, 4'd2, 1);
    send(7'b0000000, "R6 pointers in both files");

    // R7 five reads of A7; boundary exactly four
    set_slot(0, 4'd7, 1, 4'd7, 1, 0, 4'd0, 0);
    set_slot(1, 4'd7, 1, 4'd7, 1, 0, 4'd0, 0);
    set_slot(2, 4'd7, 1, 4'd0, 0, 0, 4'd0, 0);
    send(7'b0100000, "R7 five reads of one register");
    set_slot(0, 4'd7, 1, 4'd7, 1, 0, 4'd0, 0);
    set_slot(1, 4'd7, 1, 4'd7, 1, 0, 4'd0, 0);
    send(7'b0000000, "R7 exactly four reads");
    // R7 mixed: pair half + cross + pointer reads reaching five on A9
    set_slot(0, 4'd8, 1, 4'd9, 1, 0, 4'd0, 0); set_pair(0, 1, 0);
    set_slot(4, 4'd0, 0, 4'd9, 1, 1, 4'd0, 0);
    set_slot(1, 4'd9, 1, 4'd0, 0, 0, 4'd0, 0); set_mem(1, 4'd9, 0);
    send(7'b0100000, "R7 five reads via pair, cross, pointer");

    // R8 duplicate destinations
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd9, 1);
    set_slot(2, 4'd0, 0, 4'd0, 0, 0, 4'd9, 1);
    send(7'b1000000, "R8 same destination twice");
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd10, 1); set_pair(0, 0, 1);
    set_slot(1, 4'd0, 0, 4'd0, 0, 0, 4'd11, 1);
    send(7'b1000000, "R8 pair write overlaps single write");
    set_slot(0, 4'd0, 0, 4'd0, 0, 0, 4'd9, 1);
    set_slot(4, 4'd0, 0, 4'd0, 0, 0, 4'd9, 1);
    send(7'b0000000, "R8 same index different files");

    // R9 invalid slots carrying violations
    set_slot(0, 4'd7, 1, 4'd7, 1, 1, 4'd3, 1); set_pair(0, 1, 1); set_mem(0, 4'd1, 0);
    set_slot(1, 4'd7, 1, 4'd7, 1, 1, 4'd3, 1); set_pair(1, 1, 1); set_mem(1, 4'd1, 0);
    set_slot(2, 4'd7, 1, 4'd0, 0, 0, 4'd3, 1);
    slot_vld = '0;
    send(7'b0000000, "R9 all slots invalid");
    set_slot(0, 4'd0, 0, 4'd5, 1, 1, 4'd1, 1);
    set_slot(1, 4'd0, 0, 4'd6, 1, 1, 4'd1, 1); set_mem(1, 4'd1, 0);
    set_slot(2, 4'd0, 0, 4'd0, 0, 0, 4'd2, 1); set_mem(2, 4'd2, 0);
    slot_vld[1] = 1'b0;
    send(7'b0000000, "R9 invalid slot removes conflicts");

    // R10 several violations together
    set_slot(0, 4'd0, 0, 4'd5, 1, 1, 4'd0, 1); set_mem(0, 4'd1, 1);
    set_slot(1, 4'd0, 0, 4'd6, 1, 1, 4'd0, 1); set_mem(1, 4'd2, 1);
    send(7'b1010001, "R10 cross, pointer and duplicate together");

    // R11 verdict holds while idle
    repeat (4) @(negedge clk);
    check("R11 hold after idle cycles", viol, legal, 7'b1010001);
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle out_valid=%b expected 0", out_valid);
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 %0d verdicts missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule